// File: doc/BRIEF.md
# Memory-Mapped Console Port

This block is a small console peripheral on a 32-bit register bus. Software sends characters one at a time by writing a register. It reads how many received bytes are waiting, programs a 64-bit buffer address and a 32-bit length, and issues commands through a command register. Received bytes arrive on a valid/ready byte stream and are queued in an internal receive FIFO. A single level interrupt tells software that data is waiting.

Bulk transfers are not performed here. A transmit-buffer or receive-buffer command pulses a start strobe, with a direction bit, to a separate transfer engine. That engine reads the programmed address and length from this block's outputs, and it pops received bytes through a dedicated pop port. While the engine reports busy, the block stalls bus writes that would change its setup. Outgoing single characters pass through a one-byte holding register, so the bus stalls only when a second character arrives before the first has been taken.

Top module: `tty_console`

## Requirements
- R1: A read of byte offset 0x20 returns 1. A read of any other offset except 0x04 returns 0, including the write-only offsets 0x00 and 0x08 and the unused offsets 0x0C, 0x1C and 0x24 to 0x3C. Reads complete in the cycle they are presented.
- R2: A read of offset 0x04 returns the number of bytes currently held in the receive FIFO, in bits [7:0], with the upper bits zero.
- R3: The FIFO holds DEPTH (default 128) bytes. `rxReady` is high exactly while fewer than DEPTH bytes are held. An offered byte is taken only when `rxValid` and `rxReady` are both high at a clock edge.
- R4: `popData` shows the oldest held byte and `popValid` is high while the FIFO is non-empty. A cycle with `xferPop` high and `popValid` high removes that byte, so bytes leave in arrival order.
- R5: Writing 1 to the command register (offset 0x08) enables the interrupt, and writing 0 disables it. `irq` is high exactly when the interrupt is enabled and the FIFO is non-empty.
- R6: A write to offset 0x00 places bits [7:0] of the written value on `txData` and raises `txValid`. The byte stays there unchanged until it is taken by `txReady`.
- R7: A write to offset 0x00 while a character is still waiting on the transmit stream is stalled (`busReady` low) until that character is taken. It then completes and queues its own byte.
- R8: Writes to offset 0x10 and offset 0x18 set bits [31:0] and bits [63:32] of `xferPtr`. Writes to offset 0x14 set `xferLen`.
- R9: Writing 2 or 3 to the command register raises `xferStart` for the single accepting cycle, with `xferDir` equal to 0 for 2 (transmit buffer) and 1 for 3 (receive buffer). Command values other than 0 to 3 have no effect.
- R10: While `xferBusy` is high, writes to offsets 0x08, 0x10, 0x14 and 0x18 are stalled and change nothing. They complete once `xferBusy` falls.
- R11: After reset the FIFO is empty, the interrupt is disabled, `xferPtr` and `xferLen` are zero, and `txValid` is low.
- R12: Writes to offsets other than 0x00, 0x08, 0x10, 0x14 and 0x18 complete at once and change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus access request |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 6 | Byte offset within the register window |
| busWdata | input | 32 | Write data |
| busReady | output | 1 | Access completes this cycle |
| busRdata | output | 32 | Read data, valid with a completing read |
| rxValid | input | 1 | Incoming byte offered |
| rxData | input | 8 | Incoming byte |
| rxReady | output | 1 | FIFO has room |
| txValid | output | 1 | Outgoing character waiting |
| txData | output | 8 | Outgoing character |
| txReady | input | 1 | Sink takes the character |
| irq | output | 1 | Level interrupt |
| xferStart | output | 1 | Buffer transfer start strobe |
| xferDir | output | 1 | 0 = transmit buffer, 1 = receive buffer |
| xferPtr | output | 64 | Programmed buffer address |
| xferLen | output | 32 | Programmed buffer length |
| xferBusy | input | 1 | Transfer engine busy |
| xferPop | input | 1 | Engine removes the oldest FIFO byte |
| popData | output | 8 | Oldest FIFO byte |
| popValid | output | 1 | FIFO non-empty |

## Verification
The hardest state to reach is the full-FIFO boundary with the interrupt enabled. There the ready signal must drop at exactly DEPTH bytes and the interrupt must hold through every pop except the last. The stimulus fills the FIFO byte by byte and reads the occupancy register after each push. It then offers further bytes against a full queue, enables the interrupt, and drains everything through the pop port while comparing each byte and the interrupt level. The two stall cases are held open for several cycles by keeping the transmit sink or the engine's busy flag in place, and every output is checked for change before the stall is released.

// File: rtl/tty_pkg.sv
package tty_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFF_PUT   = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_COUNT = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_CMD   = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_PLO   = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_LEN   = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_PHI   = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_VER   = 6'h20;

  localparam logic [31:0] VERSION_VAL = 32'd1;

  typedef enum logic [1:0] {
    CMD_IRQ_OFF = 2'd0,
    CMD_IRQ_ON  = 2'd1,
    CMD_SEND    = 2'd2,
    CMD_RECV    = 2'd3
  } cmd_e;

  typedef struct packed {
    logic putChar;
    logic ptrLo;
    logic ptrHi;
    logic lenWr;
    logic irqOn;
    logic irqOff;
  } strobe_t;
endpackage

// File: rtl/tty_ctrl.sv
module tty_ctrl
  import tty_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic              skidFull,
  input  logic              xferBusy,
  output logic              busReady,
  output strobe_t           strb,
  output logic              xferStart,
  output logic              xferDir
);
  logic isWr, hitPut, hitCmd, hitCfg, accWr, cmdLegal;
  cmd_e cmdCode;

  always_comb begin
    isWr     = busValid && busWrite;
    hitPut   = (busAddr == OFF_PUT);
    hitCmd   = (busAddr == OFF_CMD);
    hitCfg   = hitCmd || (busAddr == OFF_PLO) || (busAddr == OFF_LEN) || (busAddr == OFF_PHI);
    busReady = !(isWr && ((hitPut && skidFull) || (hitCfg && xferBusy)));
    accWr    = isWr && busReady;
    cmdLegal = (busWdata[31:2] == '0);
    cmdCode  = cmd_e'(busWdata[1:0]);

    strb         = '0;
    strb.putChar = accWr && hitPut;
    strb.ptrLo   = accWr && (busAddr == OFF_PLO);
    strb.ptrHi   = accWr && (busAddr == OFF_PHI);
    strb.lenWr   = accWr && (busAddr == OFF_LEN);
    strb.irqOn   = accWr && hitCmd && cmdLegal && (cmdCode == CMD_IRQ_ON);
    strb.irqOff  = accWr && hitCmd && cmdLegal && (cmdCode == CMD_IRQ_OFF);
    xferStart    = accWr && hitCmd && cmdLegal &&
                   ((cmdCode == CMD_SEND) || (cmdCode == CMD_RECV));
    xferDir      = (cmdCode == CMD_RECV);
  end

  // R7
  put_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busAddr == OFF_PUT && skidFull) |-> !busReady);

  // R10
  busy_nostart_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferBusy |-> !xferStart);

  // R9
  start_has_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |-> (busValid && busWrite && busAddr == OFF_CMD));
endmodule

// File: rtl/tty_dpath.sv
module tty_dpath
  import tty_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  output logic              rxReady,
  output logic              txValid,
  output logic [7:0]        txData,
  input  logic              txReady,
  output logic              skidFull,
  output logic              irq,
  output logic [63:0]       xferPtr,
  output logic [31:0]       xferLen,
  input  logic              xferPop,
  output logic [7:0]        popData,
  output logic              popValid
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [7:0]       fifoMem [DEPTH];
  logic [IDX_W-1:0] wrIdx, rdIdx;
  logic [CNT_W-1:0] count;
  logic             intEn;
  logic [31:0]      ptrLoQ, ptrHiQ, lenQ;
  logic [7:0]       skidByte;
  logic             pushEv, popEv;

  assign rxReady  = (count != FULL_CNT);
  assign popValid = (count != '0);
  assign popData  = fifoMem[rdIdx];
  assign pushEv   = rxValid && rxReady;
  assign popEv    = xferPop && popValid;
  assign irq      = intEn && popValid;
  assign txValid  = skidFull;
  assign txData   = skidByte;
  assign xferPtr  = {ptrHiQ, ptrLoQ};
  assign xferLen  = lenQ;

  always_ff @(posedge clk) begin
    if (pushEv) fifoMem[wrIdx] <= rxData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx <= '0;
      rdIdx <= '0;
      count <= '0;
    end else begin
      if (pushEv) wrIdx <= (wrIdx == LAST_IDX) ? '0 : wrIdx + 1'b1;
      if (popEv)  rdIdx <= (rdIdx == LAST_IDX) ? '0 : rdIdx + 1'b1;
      case ({pushEv, popEv})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intEn    <= 1'b0;
      ptrLoQ   <= '0;
      ptrHiQ   <= '0;
      lenQ     <= '0;
      skidFull <= 1'b0;
      skidByte <= '0;
    end else begin
      if (strb.irqOn)  intEn  <= 1'b1;
      if (strb.irqOff) intEn  <= 1'b0;
      if (strb.ptrLo)  ptrLoQ <= busWdata;
      if (strb.ptrHi)  ptrHiQ <= busWdata;
      if (strb.lenWr)  lenQ   <= busWdata;
      if (strb.putChar) begin
        skidFull <= 1'b1;
        skidByte <= busWdata[7:0];
      end else if (txReady) begin
        skidFull <= 1'b0;
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == OFF_COUNT) busRdata = 32'(count);
    else if (busAddr == OFF_VER) busRdata = VERSION_VAL;
  end

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pushEv && !popEv) |=> $stable(count));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count == FULL_CNT && !popEv) |=> !rxReady);

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData)));

  // R5
  irq_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.irqOff |=> !irq);
endmodule

// File: rtl/tty_console.sv
module tty_console
  import tty_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busValid,
  input  logic        busWrite,
  input  logic [5:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic        busReady,
  output logic [31:0] busRdata,
  input  logic        rxValid,
  input  logic [7:0]  rxData,
  output logic        rxReady,
  output logic        txValid,
  output logic [7:0]  txData,
  input  logic        txReady,
  output logic        irq,
  output logic        xferStart,
  output logic        xferDir,
  output logic [63:0] xferPtr,
  output logic [31:0] xferLen,
  input  logic        xferBusy,
  input  logic        xferPop,
  output logic [7:0]  popData,
  output logic        popValid
);
  strobe_t strb;
  logic    skidFull;

  tty_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .skidFull(skidFull),
    .xferBusy(xferBusy), .busReady(busReady), .strb(strb),
    .xferStart(xferStart), .xferDir(xferDir)
  );

  tty_dpath #(.DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rxValid(rxValid),
    .rxData(rxData), .rxReady(rxReady), .txValid(txValid), .txData(txData),
    .txReady(txReady), .skidFull(skidFull), .irq(irq), .xferPtr(xferPtr),
    .xferLen(xferLen), .xferPop(xferPop), .popData(popData),
    .popValid(popValid)
  );
endmodule

// File: tb/tb_tty_console.sv
module tb_tty_console;
  localparam int DEPTH = 128;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busReady;
  logic [31:0] busRdata;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxReady, txValid, txReady = 1'b1;
  logic [7:0]  txData;
  logic        irq, xferStart, xferDir, xferBusy = 1'b0, xferPop = 1'b0;
  logic [63:0] xferPtr;
  logic [31:0] xferLen;
  logic [7:0]  popData;
  logic        popValid;

  int testsRun = 0, testsFailed = 0;
  int txCnt = 0, startCnt = 0;
  logic [7:0] txLog [64];
  logic lastDir = 1'b0;

  always #2 clk = ~clk;

  tty_console #(.DEPTH(DEPTH)) dut (.*);

  always @(posedge clk) begin
    if (txValid && txReady) begin
      txLog[txCnt % 64] <= txData;
      txCnt <= txCnt + 1;
    end
    if (xferStart) begin
      startCnt <= startCnt + 1;
      lastDir  <= xferDir;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = a; busWdata = d;
    #1;
    while (!busReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    busValid = 0; busWrite = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
    @(posedge clk); #1;
    busValid = 0;
  endtask

  task automatic pushByte(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1; rxData = b;
    @(posedge clk); #1;
    rxValid = 0;
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  initial begin
    #(4 * 150000);
    chk(0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    logic [31:0] v;
    int s0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R11 reset state
    #1;
    chk(irq == 0, "R11 irq", irq, 0);
    chk(xferPtr == 0, "R11 ptr", xferPtr, 0);
    chk(xferLen == 0, "R11 len", xferLen, 0);
    chk(txValid == 0, "R11 txValid", txValid, 0);
    chk(popValid == 0 && rxReady == 1, "R11 fifo empty", popValid, 0);

    // R1 R2 sweep of every offset
    for (int a = 0; a < 64; a += 4) begin
      rd(6'(a), v);
      chk(v == ((a == 32) ? 1 : 0), $sformatf("R1 R2 read offset 0x%0h", a), v, (a == 32) ? 1 : 0);
    end

    // R8 pointer and length
    wr(6'h10, 32'h1234_5678);
    wr(6'h18, 32'h9abc_def0);
    wr(6'h14, 32'd77);
    chk(xferPtr == 64'h9abc_def0_1234_5678, "R8 ptr", xferPtr, 64'h9abc_def0_1234_5678);
    chk(xferLen == 77, "R8 len", xferLen, 77);

    // R12 unimplemented writes
    s0 = startCnt;
    foreach (v[i]) if (i < 0) v = 0;
    wr(6'h0C, 32'hFFFF_FFFF); wr(6'h1C, 32'h1); wr(6'h24, 32'h2);
    wr(6'h3C, 32'h3); wr(6'h04, 32'h5); wr(6'h20, 32'h6);
    #1;
    chk(xferPtr == 64'h9abc_def0_1234_5678 && xferLen == 77, "R12 cfg unchanged", xferLen, 77);
    chk(!txValid && !irq && startCnt == s0, "R12 no tx/irq/start", {txValid, irq}, 0);
    rd(6'h04, v);
    chk(v == 0, "R12 count unchanged", v, 0);

    // R2 R3 fill the FIFO
    for (int i = 0; i < DEPTH; i++) begin
      pushByte(pat(i));
      rd(6'h04, v);
      chk(v == i + 1, "R2 count after push", v, i + 1);
      chk(irq == 0, "R5 irq while disabled", irq, 0);
    end
    chk(rxReady == 0, "R3 ready low when full", rxReady, 0);
    pushByte(8'hEE); pushByte(8'hEF);
    rd(6'h04, v);
    chk(v == DEPTH, "R3 full ignores offers", v, DEPTH);

    // R5 enable/disable
    wr(6'h08, 32'd1); #1;
    chk(irq == 1, "R5 irq on", irq, 1);
    wr(6'h08, 32'd0); #1;
    chk(irq == 0, "R5 irq off", irq, 0);
    wr(6'h08, 32'd1);
    // R9 illegal codes ignored
    for (int c = 4; c < 8; c++) wr(6'h08, 32'(c));
    wr(6'h08, 32'h0000_0100);
    #1;
    chk(irq == 1 && startCnt == s0, "R9 illegal codes no effect", irq, 1);

    // R4 drain in order
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      chk(popValid && popData == pat(i), "R4 pop order", popData, pat(i));
      chk(irq == 1, "R5 irq held while data", irq, 1);
      xferPop = 1;
      @(posedge clk); #1;
      xferPop = 0;
    end
    #1;
    chk(irq == 0 && popValid == 0, "R5 irq drops when drained", irq, 0);
    rd(6'h04, v);
    chk(v == 0, "R2 count after drain", v, 0);
    chk(rxReady == 1, "R3 ready after drain", rxReady, 1);
    wr(6'h08, 32'd0);

    // R9 transfer commands
    wr(6'h08, 32'd2);
    chk(startCnt == s0 + 1 && lastDir == 0, "R9 send start", {startCnt - s0, lastDir}, 2);
    wr(6'h08, 32'd3);
    chk(startCnt == s0 + 2 && lastDir == 1, "R9 recv start", {startCnt - s0, lastDir}, 5);

    // R10 busy stalls config writes
    xferBusy = 1;
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = 6'h10; busWdata = 32'hDEAD_BEEF;
    for (int k = 0; k < 4; k++) begin
      #1 chk(busReady == 0, "R10 ptr stalled", busReady, 0);
      @(negedge clk);
    end
    chk(xferPtr[31:0] == 32'h1234_5678, "R10 ptr unchanged", xferPtr[31:0], 32'h1234_5678);
    busAddr = 6'h08; busWdata = 32'd2;
    for (int k = 0; k < 3; k++) begin
      #1 chk(busReady == 0 && startCnt == s0 + 2, "R10 cmd stalled", busReady, 0);
      @(negedge clk);
    end
    xferBusy = 0;
    #1 chk(busReady == 1, "R10 released", busReady, 1);
    @(posedge clk); #1;
    busValid = 0; busWrite = 0;
    chk(startCnt == s0 + 3 && lastDir == 0, "R10 cmd completes", startCnt - s0, 3);

    // R6 put-char sweep
    s0 = txCnt;
    for (int k = 0; k < 8; k++) begin
      wr(6'h00, 32'h1234_5600 + 32'(k * 29));
      @(posedge clk); #1;
    end
    for (int k = 0; k < 8; k++)
      chk(txLog[(s0 + k) % 64] == 8'(k * 29), "R6 low byte sent", txLog[(s0 + k) % 64], 8'(k * 29));
    chk(txCnt == s0 + 8, "R6 one byte per write", txCnt - s0, 8);

    // R7 skid stall
    txReady = 0;
    s0 = txCnt;
    wr(6'h00, 32'hAB);
    #1 chk(txValid && txData == 8'hAB, "R6 byte held", txData, 8'hAB);
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = 6'h00; busWdata = 32'hCD;
    for (int k = 0; k < 4; k++) begin
      #1 chk(busReady == 0 && txData == 8'hAB, "R7 put stalled", busReady, 0);
      @(negedge clk);
    end
    txReady = 1;
    #1 chk(busReady == 0, "R7 still stalled at release", busReady, 0);
    @(posedge clk); #1;
    chk(busReady == 1, "R7 completes after accept", busReady, 1);
    @(posedge clk); #1;
    busValid = 0; busWrite = 0;
    @(posedge clk); #1;
    chk(txCnt == s0 + 2, "R7 both bytes sent", txCnt - s0, 2);
    chk(txLog[s0 % 64] == 8'hAB && txLog[(s0 + 1) % 64] == 8'hCD, "R7 order", txLog[(s0 + 1) % 64], 8'hCD);

    finishRun();
  end
endmodule